// File: doc/BRIEF.md
# Inter-Processor Interrupt Generation Register Bank

This block is a small memory-mapped register bank through which any bus master can signal another processor core. A write to one of its registers raises a single-cycle interrupt pulse on the chosen target. Twelve interrupt generation registers serve eight DSP cores and four application cores. Eight NMI generation registers raise non-maskable pulses on the eight DSP cores.

Each interrupt generation register also holds a 28-bit source-identification field. The writer fills it and the receiving software reads it back to learn who raised the interrupt. The meaning of each source bit is left to software convention. The pulse bit itself never holds state: it fires on the write and reads back as zero.

The bank is driven by a simple single-cycle register bus. The bus has a byte address, a write strobe with write data, and a read strobe. Read data arrives in the cycle after the read strobe.

Top module: `ipc_irq_gen`

## Requirements
- R1: A write with data bit 0 = 1 to NMI register n (address 0x00 + 4n, n = 0..7) drives `dsp_nmi_o[n]` high for exactly the one cycle after the write edge.
- R2: A write with data bit 0 = 0 to any register produces no pulse on any output.
- R3: Reading an NMI register (0x00..0x1C) always returns zero, whatever was written to it before.
- R4: A write with data bit 0 = 1 to interrupt register i (address 0x40 + 4i) pulses `dsp_irq_o[i]` for i = 0..7, and pulses `app_irq_o[i-8]` for i = 8..11. The pulse lasts one cycle and comes in the cycle after the write edge.
- R5: Each write to an interrupt register stores write-data bits 31:4 as its source field, with source bit k at bit k+4. A read returns the stored field in bits 31:4.
- R6: Bits 3:0 of an interrupt register are never stored and always read as zero. A write that sets the pulse bit still stores bits 31:4 exactly as written.
- R7: Writes in consecutive cycles give pulses in consecutive cycles. At most one pulse output is high in any cycle, and a pulse never lasts past one cycle unless a new qualifying write follows.
- R8: Unmapped or unaligned addresses (for example 0x20..0x3C, 0x70 and above, 0x41) read zero. Writes to them produce no pulse and change no stored field.
- R9: `bus_rdata` carries the addressed value in the cycle after `bus_rd` is sampled high, and is zero otherwise. A read in the same cycle as a write to the same register returns the value held before that write.
- R10: A synchronous active-high reset clears all source fields and holds every pulse output and `bus_rdata` at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| dsp_irq_o | output | 8 | Interrupt pulses to the DSP cores |
| app_irq_o | output | 4 | Interrupt pulses to the application cores |
| dsp_nmi_o | output | 8 | NMI pulses to the DSP cores |

## Verification
Each result of this block is due one cycle after the bus edge that causes it. A pulse is high for the cycle after the write edge and low again one cycle later. Read data appears in the cycle after the read edge and reflects the register as it stood before any write in that same cycle. The bench drives one bus operation per cycle and queues the outputs it expects for the following cycle. A monitor compares each queued entry a short delay after the next rising edge, so every comparison lands in exactly the cycle where that result must be visible, covering back-to-back and simultaneous read and write cases.

// File: rtl/ipc_irq_gen.sv
module ipc_irq_gen #(
  parameter int N_DSP    = 8,
  parameter int N_APP    = 4,
  parameter int AW       = 8,
  parameter int DW       = 32,
  parameter int SRC_W    = 28,
  parameter int NMI_BASE = 'h00,
  parameter int IRQ_BASE = 'h40
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_wr,
  input  logic [DW-1:0]    bus_wdata,
  input  logic             bus_rd,
  output logic [DW-1:0]    bus_rdata,
  output logic [N_DSP-1:0] dsp_irq_o,
  output logic [N_APP-1:0] app_irq_o,
  output logic [N_DSP-1:0] dsp_nmi_o
);
  localparam int N_IRQ   = N_DSP + N_APP;
  localparam int SRC_LSB = DW - SRC_W;

  logic [N_DSP-1:0] nmi_hit, nmi_q;
  logic [N_IRQ-1:0] irq_hit, irq_q;
  logic [SRC_W-1:0] src_q [N_IRQ];
  logic [DW-1:0]    rd_mux;
  logic             fire;

  assign fire = bus_wr && bus_wdata[0];

  for (genvar g = 0; g < N_DSP; g++) begin : g_nmi
    localparam logic [AW-1:0] A = AW'(NMI_BASE + 4*g);
    assign nmi_hit[g] = (bus_addr == A);
  end

  for (genvar g = 0; g < N_IRQ; g++) begin : g_irq
    localparam logic [AW-1:0] A = AW'(IRQ_BASE + 4*g);
    assign irq_hit[g] = (bus_addr == A);
    always_ff @(posedge clk) begin
      if (rst)                       src_q[g] <= '0;
      else if (bus_wr && irq_hit[g]) src_q[g] <= bus_wdata[DW-1:SRC_LSB];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      nmi_q <= '0;
      irq_q <= '0;
    end else begin
      nmi_q <= fire ? nmi_hit : '0;
      irq_q <= fire ? irq_hit : '0;
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < N_IRQ; i++)
      if (irq_hit[i]) rd_mux = {src_q[i], {SRC_LSB{1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= bus_rd ? rd_mux : '0;
  end

  assign dsp_nmi_o = nmi_q;
  assign dsp_irq_o = irq_q[N_DSP-1:0];
  assign app_irq_o = irq_q[N_IRQ-1:N_DSP];
endmodule

// File: rtl/ipc_irq_gen_chk.sv
module ipc_irq_gen_chk #(
  parameter int N_DSP    = 8,
  parameter int N_APP    = 4,
  parameter int AW       = 8,
  parameter int DW       = 32,
  parameter int SRC_W    = 28,
  parameter int NMI_BASE = 'h00,
  parameter int IRQ_BASE = 'h40
) (
  input logic             clk,
  input logic             rst,
  input logic [AW-1:0]    bus_addr,
  input logic             bus_wr,
  input logic [DW-1:0]    bus_wdata,
  input logic             bus_rd,
  input logic [DW-1:0]    bus_rdata,
  input logic [N_DSP-1:0] dsp_irq_o,
  input logic [N_APP-1:0] app_irq_o,
  input logic [N_DSP-1:0] dsp_nmi_o
);
  localparam int N_IRQ = N_DSP + N_APP;
  localparam logic [AW:0] NMI_END = (AW+1)'(NMI_BASE + 4*N_DSP);
  localparam logic [AW:0] IRQ_END = (AW+1)'(IRQ_BASE + 4*N_IRQ);

  logic [2*N_DSP+N_APP-1:0] pulses;
  logic [N_IRQ-1:0]         irq_v;
  assign pulses = {dsp_nmi_o, app_irq_o, dsp_irq_o};
  assign irq_v  = {app_irq_o, dsp_irq_o};

  for (genvar g = 0; g < N_DSP; g++) begin : g_nmi
    localparam logic [AW-1:0] A = AW'(NMI_BASE + 4*g);
    assert_nmi_pulse_R1: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && bus_addr == A && bus_wdata[0]) |=> dsp_nmi_o[g]);
  end

  for (genvar g = 0; g < N_IRQ; g++) begin : g_irq
    localparam logic [AW-1:0] A = AW'(IRQ_BASE + 4*g);
    assert_irq_pulse_R4: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && bus_addr == A && bus_wdata[0]) |=> irq_v[g]);
  end

  assert_zero_write_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_wdata[0]) |=> (pulses == '0));

  assert_nmi_read_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && {1'b0, bus_addr} < NMI_END) |=> (bus_rdata == '0));

  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pulses));

  assert_pulse_cause_R7: assert property (@(posedge clk) disable iff (rst)
    (pulses != '0) |-> $past(bus_wr && bus_wdata[0]));

  assert_unmapped_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && {1'b0, bus_addr} >= IRQ_END) |=> (pulses == '0));

  assert_idle_rdata_R9: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == '0));
endmodule

bind ipc_irq_gen ipc_irq_gen_chk #(
  .N_DSP(N_DSP), .N_APP(N_APP), .AW(AW), .DW(DW), .SRC_W(SRC_W),
  .NMI_BASE(NMI_BASE), .IRQ_BASE(IRQ_BASE)
) u_chk (.*);

// File: tb/tb_ipc_irq_gen.sv
`timescale 1ns/1ps
module tb_ipc_irq_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic [7:0]  dsp_irq_o;
  logic [3:0]  app_irq_o;
  logic [7:0]  dsp_nmi_o;

  always #4 clk = ~clk;

  ipc_irq_gen dut (.*);

  typedef struct packed {
    logic [7:0]  nmi;
    logic [7:0]  dsp;
    logic [3:0]  app;
    logic [31:0] rdata;
  } exp_t;

  exp_t  expq[$];
  string tagq[$];
  int    vectors = 0;
  int    errors  = 0;
  bit    done    = 0;
  logic [27:0] m_src [12];

  function automatic logic [31:0] model_read(input logic [7:0] a);
    for (int i = 0; i < 12; i++)
      if (a == 8'(8'h40 + 4*i)) return {m_src[i], 4'b0};
    return 32'h0;
  endfunction

  task automatic op(input bit w, input bit r, input logic [7:0] a,
                    input logic [31:0] d, input string t);
    exp_t e;
    @(negedge clk);
    rst = 1'b0; bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
    e = '0;
    if (r) e.rdata = model_read(a);
    if (w && d[0]) begin
      for (int n = 0; n < 8; n++)  if (a == 8'(4*n))         e.nmi[n] = 1'b1;
      for (int i = 0; i < 8; i++)  if (a == 8'(8'h40 + 4*i)) e.dsp[i] = 1'b1;
      for (int i = 8; i < 12; i++) if (a == 8'(8'h40 + 4*i)) e.app[i-8] = 1'b1;
    end
    if (w)
      for (int i = 0; i < 12; i++) if (a == 8'(8'h40 + 4*i)) m_src[i] = d[31:4];
    expq.push_back(e);
    tagq.push_back(t);
  endtask

  task automatic do_reset(input int cycles);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      rst = 1'b1; bus_wr = 1'b1; bus_rd = 1'b1; bus_addr = 8'h40; bus_wdata = '1;
      for (int i = 0; i < 12; i++) m_src[i] = '0;
      expq.push_back('0);
      tagq.push_back("R10");
    end
  endtask

  initial begin : monitor
    exp_t  e;
    string t;
    forever begin
      @(posedge clk); #2;
      if (expq.size() > 0) begin
        e = expq.pop_front();
        t = tagq.pop_front();
        vectors++;
        if (dsp_nmi_o !== e.nmi || dsp_irq_o !== e.dsp ||
            app_irq_o !== e.app || bus_rdata !== e.rdata) begin
          errors++;
          $display("FAIL %s: nmi=%h dsp=%h app=%h rdata=%h expected nmi=%h dsp=%h app=%h rdata=%h",
                   t, dsp_nmi_o, dsp_irq_o, app_irq_o, bus_rdata,
                   e.nmi, e.dsp, e.app, e.rdata);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin : driver
    for (int i = 0; i < 12; i++) m_src[i] = '0;
    do_reset(3);
    for (int i = 0; i < 12; i++) op(0, 1, 8'(8'h40 + 4*i), 0, "R10");

    for (int n = 0; n < 8; n++) op(1, 0, 8'(4*n), 32'h1, "R1");
    op(0, 0, 0, 0, "R7");
    op(1, 0, 8'h08, 32'h1, "R7");
    op(1, 0, 8'h08, 32'h1, "R7");
    op(1, 0, 8'h44, 32'h1, "R7");
    op(0, 0, 0, 0, "R7");

    op(1, 0, 8'h0C, 32'hFFFF_FFFE, "R2");
    op(1, 0, 8'h48, 32'h0000_0010, "R2");
    op(0, 1, 8'h48, 0, "R2");

    op(1, 0, 8'h10, 32'hFFFF_FFFF, "R3");
    op(0, 1, 8'h10, 0, "R3");
    op(0, 1, 8'h00, 0, "R3");
    op(0, 1, 8'h1C, 0, "R3");

    for (int i = 0; i < 12; i++)
      op(1, 0, 8'(8'h40 + 4*i), {28'(32'h0ABC_D01 * (i + 1)), 4'h1}, "R4");
    for (int i = 0; i < 12; i++) op(0, 1, 8'(8'h40 + 4*i), 0, "R5");

    op(1, 0, 8'h60, 32'hFFFF_FFFF, "R6");
    op(0, 1, 8'h60, 0, "R6");
    op(1, 0, 8'h64, 32'h8000_000E, "R6");
    op(0, 1, 8'h64, 0, "R6");

    op(1, 1, 8'h20, 32'hFFFF_FFFF, "R8");
    op(1, 1, 8'h3C, 32'hFFFF_FFFF, "R8");
    op(1, 1, 8'h70, 32'hFFFF_FFFF, "R8");
    op(1, 1, 8'h41, 32'hFFFF_FFFF, "R8");
    op(1, 1, 8'hFC, 32'hFFFF_FFFF, "R8");
    op(0, 1, 8'h40, 0, "R8");
    op(0, 1, 8'h6C, 0, "R8");

    op(1, 1, 8'h50, 32'h1234_5671, "R9");
    op(0, 1, 8'h50, 0, "R9");
    op(0, 0, 8'h50, 0, "R9");

    do_reset(2);
    op(0, 1, 8'h50, 0, "R10");
    op(0, 1, 8'h6C, 0, "R10");
    op(0, 0, 0, 0, "R10");

    while (expq.size() > 0) @(posedge clk);
    #3;
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule